// File: doc/BRIEF.md
# GPIO Port with Per-Line Interrupt Detection

This block is a 32-line general-purpose I/O port that sits behind a simple memory-mapped register bus with a setup phase and an access phase. Software picks a direction for each line and drives output values. It can change individual output bits through dedicated set and clear addresses, so no read-modify-write is needed. It reads the pin values after a two-flop synchronizer.

Each line can raise an interrupt. Three configuration bits per line choose the trigger: the sense bit picks edge or level, the polarity bit picks high/rising or low/falling, and the dual-edge bit makes an edge line react to both directions. An enable gates each line before detection. Edge events are latched until software writes a one to the clear address. Level status follows the pin while it is active. A mask removes lines from the masked view, and the OR of the masked view drives a single interrupt output.

The pull-enable and pull-select registers only hold their values for pad logic outside the block.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero and `pin_oe`, `pin_out` and `irq` are all zero.
- R2: Offset 0x08 holds direction, where a 1 makes the line an output on `pin_oe`. Offset 0x00 holds output data, which drives `pin_out`. Both read back.
- R3: A write to offset 0x10 sets the output bits where the written word has a one. A write to offset 0x14 clears those bits. All other output bits keep their value.
- R4: Offset 0x04 reads the pins through a two-flop synchronizer. A pin change present before rising edge k is readable after edge k+1 and not after edge k.
- R5: The trigger bits sit at offset 0x34 (sense: 1 = level, 0 = edge), offset 0x38 (dual-edge) and offset 0x3C (polarity). With sense 0, dual-edge 0 and polarity 0, a rising edge latches raw status (offset 0x24). The status and `irq` appear after the third rising edge that follows the pin change. A falling edge or a steady pin latches nothing.
- R6: With sense 0, dual-edge 0 and polarity 1, only a falling edge latches status.
- R7: With sense 0 and dual-edge 1, either transition latches status, whatever the polarity bit.
- R8: With sense 1, raw status follows the active level: high when polarity is 0, low when polarity is 1. The dual-edge bit is ignored. A clear write does not remove level status while the level is active.
- R9: Writing a 1 to a bit of offset 0x30 clears that line's latched edge status. Writing a 0 leaves it unchanged.
- R10: Offset 0x20 holds the per-line enable. A line with enable 0 has raw status 0, and clearing an enable bit drops that line's status.
- R11: Offset 0x2C holds the mask. The masked status at offset 0x28 is raw AND NOT mask, and `irq` is the OR of the masked status bits.
- R12: Offsets 0x18 and 0x1C store pull enable and pull select. They read back what was written and do not affect `pin_out` or `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from `paddr` |
| pin_in | input | 32 | Pin input values (asynchronous) |
| pin_out | output | 32 | Output data |
| pin_oe | output | 32 | Output enable per line |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong trigger decode, for example swapped polarity or an ignored dual-edge bit, shows on `irq` and raw status three clocks after the pin moves. The bench sweeps each mode against each pin transition. A status flop that fails to hold, or fails to clear, shows as a raw readback that differs after the next bus write. The checks write zeros to the clear address and clear a level that is still active. A wrong set or clear alias corrupts neighbouring bits of `pin_out` on the very next clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned OFS_DOUT  = 'h00;
  localparam int unsigned OFS_DIN   = 'h04;
  localparam int unsigned OFS_DIR   = 'h08;
  localparam int unsigned OFS_SET   = 'h10;
  localparam int unsigned OFS_CLR   = 'h14;
  localparam int unsigned OFS_PEN   = 'h18;
  localparam int unsigned OFS_PSEL  = 'h1C;
  localparam int unsigned OFS_IEN   = 'h20;
  localparam int unsigned OFS_RAW   = 'h24;
  localparam int unsigned OFS_MSK_S = 'h28;
  localparam int unsigned OFS_MASK  = 'h2C;
  localparam int unsigned OFS_ICLR  = 'h30;
  localparam int unsigned OFS_SENSE = 'h34;
  localparam int unsigned OFS_DUAL  = 'h38;
  localparam int unsigned OFS_POL   = 'h3C;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] cfg_dual,
  input  logic [W-1:0] cfg_pol,
  output logic [W-1:0] edge_ev,
  output logic [W-1:0] lvl_act
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic rise, fall;
    assign rise       = cur[i] & ~prev[i];
    assign fall       = ~cur[i] & prev[i];
    assign edge_ev[i] = cfg_dual[i] ? (rise | fall) : (cfg_pol[i] ? fall : rise);
    assign lvl_act[i] = cfg_pol[i] ? ~cur[i] : cur[i];
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] en,
  input  logic [W-1:0] sense_lvl,
  input  logic [W-1:0] edge_ev,
  input  logic [W-1:0] lvl_act,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw
);
  logic [W-1:0] raw_q, raw_n;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      raw_n[i] = en[i] & (sense_lvl[i] ? lvl_act[i]
                                       : (edge_ev[i] | (raw_q[i] & ~clr[i])));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_n;
  end

  assign raw = raw_q;

  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q & ~$past(en)) == '0);

  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_q & $past(clr & ~sense_lvl & ~edge_ev)) == '0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_q & $past(raw_q & en & ~clr & ~sense_lvl))
             == $past(raw_q & en & ~clr & ~sense_lvl));

  p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_q & $past(sense_lvl)) == $past(en & sense_lvl & lvl_act));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [W-1:0]      pwdata,
  output logic [W-1:0]      prdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic wr;
  assign wr = psel & penable & pwrite;

  logic [W-1:0] dout_q, dir_q, pen_q, psel_q, ien_q, mask_q, sense_q, dual_q, pol_q;
  logic [W-1:0] dout_n, dir_n, pen_n, psel_n, ien_n, mask_n, sense_n, dual_n, pol_n;
  logic [W-1:0] clr_pulse;

  always_comb begin
    dout_n    = dout_q;
    dir_n     = dir_q;
    pen_n     = pen_q;
    psel_n    = psel_q;
    ien_n     = ien_q;
    mask_n    = mask_q;
    sense_n   = sense_q;
    dual_n    = dual_q;
    pol_n     = pol_q;
    clr_pulse = '0;
    if (wr) begin
      case (paddr)
        ADDR_W'(OFS_DOUT):  dout_n    = pwdata;
        ADDR_W'(OFS_DIR):   dir_n     = pwdata;
        ADDR_W'(OFS_SET):   dout_n    = dout_q | pwdata;
        ADDR_W'(OFS_CLR):   dout_n    = dout_q & ~pwdata;
        ADDR_W'(OFS_PEN):   pen_n     = pwdata;
        ADDR_W'(OFS_PSEL):  psel_n    = pwdata;
        ADDR_W'(OFS_IEN):   ien_n     = pwdata;
        ADDR_W'(OFS_MASK):  mask_n    = pwdata;
        ADDR_W'(OFS_ICLR):  clr_pulse = pwdata;
        ADDR_W'(OFS_SENSE): sense_n   = pwdata;
        ADDR_W'(OFS_DUAL):  dual_n    = pwdata;
        ADDR_W'(OFS_POL):   pol_n     = pwdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dout_q  <= '0;
      dir_q   <= '0;
      pen_q   <= '0;
      psel_q  <= '0;
      ien_q   <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      dual_q  <= '0;
      pol_q   <= '0;
    end else if (wr) begin
      dout_q  <= dout_n;
      dir_q   <= dir_n;
      pen_q   <= pen_n;
      psel_q  <= psel_n;
      ien_q   <= ien_n;
      mask_q  <= mask_n;
      sense_q <= sense_n;
      dual_q  <= dual_n;
      pol_q   <= pol_n;
    end
  end

  logic [W-1:0] cur, prev, edge_ev, lvl_act, raw, masked;

  gpio_in_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .pin_in(pin_in), .cur(cur), .prev(prev)
  );

  gpio_trig_detect #(.W(W)) u_det (
    .cur(cur), .prev(prev), .cfg_dual(dual_q), .cfg_pol(pol_q),
    .edge_ev(edge_ev), .lvl_act(lvl_act)
  );

  gpio_irq_status #(.W(W)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .en(ien_q), .sense_lvl(sense_q),
    .edge_ev(edge_ev), .lvl_act(lvl_act), .clr(clr_pulse), .raw(raw)
  );

  assign masked  = raw & ~mask_q;
  assign irq     = |masked;
  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

  always_comb begin
    case (paddr)
      ADDR_W'(OFS_DOUT):  prdata = dout_q;
      ADDR_W'(OFS_DIN):   prdata = cur;
      ADDR_W'(OFS_DIR):   prdata = dir_q;
      ADDR_W'(OFS_PEN):   prdata = pen_q;
      ADDR_W'(OFS_PSEL):  prdata = psel_q;
      ADDR_W'(OFS_IEN):   prdata = ien_q;
      ADDR_W'(OFS_RAW):   prdata = raw;
      ADDR_W'(OFS_MSK_S): prdata = masked;
      ADDR_W'(OFS_MASK):  prdata = mask_q;
      ADDR_W'(OFS_SENSE): prdata = sense_q;
      ADDR_W'(OFS_DUAL):  prdata = dual_q;
      ADDR_W'(OFS_POL):   prdata = pol_q;
      default:            prdata = '0;
    endcase
  end

  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr && paddr == ADDR_W'(OFS_SET)) |=> pin_out == ($past(pin_out) | $past(pwdata)));

  p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr && paddr == ADDR_W'(OFS_CLR)) |=> pin_out == ($past(pin_out) & ~$past(pwdata)));

  p_pull_hold_r12: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr && paddr == ADDR_W'(OFS_PEN)) |=> pen_q == $past(pwdata));
endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata, pin_in, pin_out, pin_oe;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {sense, dual, pol, pin_before, pin_after, expected_status}
  localparam logic [5:0] VEC [14] = '{
    6'b000_01_1, 6'b000_10_0, 6'b000_11_0,
    6'b001_10_1, 6'b001_01_0,
    6'b010_01_1, 6'b010_10_1, 6'b011_00_0, 6'b011_10_1,
    6'b100_01_1, 6'b100_10_0,
    6'b101_10_1, 6'b101_01_0,
    6'b110_01_1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    paddr = a;
    #1 d = prdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; pin_in = 0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);

    // R1 reset state
    rd(8'h00, d); chk("R1 dout", d, 0);
    rd(8'h08, d); chk("R1 dir", d, 0);
    rd(8'h20, d); chk("R1 ien", d, 0);
    rd(8'h24, d); chk("R1 raw", d, 0);
    rd(8'h34, d); chk("R1 sense", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_out", pin_out, 0);

    // R2 direction and output data
    wr(8'h08, 32'hF0F0_0000);
    wr(8'h00, 32'h1234_5678);
    chk("R2 pin_oe", pin_oe, 32'hF0F0_0000);
    chk("R2 pin_out", pin_out, 32'h1234_5678);
    rd(8'h08, d); chk("R2 dir read", d, 32'hF0F0_0000);

    // R3 set / clear aliases
    wr(8'h10, 32'h0000_00FF);
    chk("R3 set", pin_out, 32'h1234_56FF);
    wr(8'h14, 32'h1200_0000);
    chk("R3 clr", pin_out, 32'h0034_56FF);
    rd(8'h00, d); chk("R3 read", d, 32'h0034_56FF);

    // R12 pull registers held only
    wr(8'h18, 32'hA5A5_0000);
    wr(8'h1C, 32'h0000_C3C3);
    rd(8'h18, d); chk("R12 pen", d, 32'hA5A5_0000);
    rd(8'h1C, d); chk("R12 psel", d, 32'h0000_C3C3);
    chk("R12 pin_out", pin_out, 32'h0034_56FF);
    chk("R12 pin_oe", pin_oe, 32'hF0F0_0000);

    // R4 synchronizer latency
    pin_in = 32'hDEAD_BEEF;
    wait_n(1);
    rd(8'h04, d); chk("R4 after one edge", d, 0);
    wait_n(1);
    rd(8'h04, d); chk("R4 after two edges", d, 32'hDEAD_BEEF);
    pin_in = 0;
    wait_n(4);

    // Trigger mode table on line 3 (R5..R8)
    wr(8'h2C, 0);
    wr(8'h20, 32'h8);
    for (int v = 0; v < 14; v++) begin
      logic [5:0] e;
      string tag;
      e = VEC[v];
      tag = e[5] ? "R8 level" : (e[4] ? "R7 dual" : (e[3] ? "R6 fall" : "R5 rise"));
      pin_in = {28'd0, e[2], 3'd0};
      wr(8'h34, {28'd0, e[5], 3'd0});
      wr(8'h38, {28'd0, e[4], 3'd0});
      wr(8'h3C, {28'd0, e[3], 3'd0});
      wait_n(4);
      wr(8'h30, 32'h8);
      pin_in = {28'd0, e[1], 3'd0};
      wait_n(4);
      rd(8'h24, d); chk($sformatf("%s vec%0d raw", tag, v), d, {28'd0, e[0], 3'd0});
      chk($sformatf("%s vec%0d irq", tag, v), {31'd0, irq}, {31'd0, e[0]});
    end

    // R5 latency: status appears after the third rising edge
    wr(8'h34, 0); wr(8'h38, 0); wr(8'h3C, 0);
    pin_in = 0; wait_n(4); wr(8'h30, 32'h8);
    pin_in = 32'h8;
    wait_n(2);
    chk("R5 not yet after two edges", {31'd0, irq}, 0);
    wait_n(1);
    chk("R5 after three edges", {31'd0, irq}, 1);

    // R9 write-one-to-clear
    rd(8'h24, d); chk("R9 latched", d, 32'h8);
    wr(8'h30, 32'hFFFF_FFF7);
    rd(8'h24, d); chk("R9 zero write ignored", d, 32'h8);
    wr(8'h30, 32'h8);
    rd(8'h24, d); chk("R9 cleared", d, 0);

    // R11 mask
    pin_in = 0; wait_n(4); pin_in = 32'h8; wait_n(4);
    chk("R11 irq unmasked", {31'd0, irq}, 1);
    wr(8'h2C, 32'h8);
    rd(8'h28, d); chk("R11 masked status", d, 0);
    rd(8'h24, d); chk("R11 raw kept", d, 32'h8);
    chk("R11 irq masked", {31'd0, irq}, 0);
    wr(8'h2C, 0);
    rd(8'h28, d); chk("R11 masked restored", d, 32'h8);
    chk("R11 irq restored", {31'd0, irq}, 1);

    // R10 enable gating
    wr(8'h20, 0);
    wait_n(1);
    rd(8'h24, d); chk("R10 dropped", d, 0);
    pin_in = 0; wait_n(4); pin_in = 32'h8; wait_n(4);
    rd(8'h24, d); chk("R10 disabled edge", d, 0);
    chk("R10 irq", {31'd0, irq}, 0);

    // R8 level status cannot be cleared while active
    wr(8'h34, 32'h8);
    wr(8'h20, 32'h8);
    wait_n(2);
    rd(8'h24, d); chk("R8 level active", d, 32'h8);
    wr(8'h30, 32'h8);
    rd(8'h24, d); chk("R8 clear ignored", d, 32'h8);
    pin_in = 0; wait_n(4);
    rd(8'h24, d); chk("R8 level gone", d, 0);

    // R7 many lines on both edges
    wr(8'h34, 0);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    pin_in = 32'hA5A5_A5A5;
    wait_n(4);
    rd(8'h24, d); chk("R7 multi line", d, 32'hA5A5_A5A5);
    chk("R7 multi irq", {31'd0, irq}, 1);

    // R1 reset again mid-run
    rst_n = 1'b0;
    wait_n(1);
    chk("R1 re-reset pin_oe", pin_oe, 0);
    chk("R1 re-reset irq", {31'd0, irq}, 0);
    rd(8'h24, d); chk("R1 re-reset raw", d, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule